// File: doc/BRIEF.md
# Adaptive Multi-Period Reciprocal Period Meter

This block times a single asynchronous digital input against its own fast reference clock. It measures the input edge to edge, from one rising edge to the next. Within each refresh window it sums the reference ticks of every whole input period that finishes, and it stops adding periods once a fixed cap is reached. A fast input therefore yields many periods per result and a slow input yields few, while results still arrive at a steady rate. The caller obtains the average period by dividing the tick total by the period count. That division is left outside the block.

The refresh length and the timeout length are run-time inputs, both counted in reference clock cycles. A timing interval is not cut off at a window boundary. When one input period is longer than the window, that period is reported at the first boundary after it ends, as a single period. When no rising edge arrives for the timeout length, the block raises a no-signal flag, issues a result with a count of zero, and waits for the input to return.

Top module: `recip_period_meter`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `result_valid`, `period_count`, `tick_total` and `no_signal` are all 0.
- R2: Only intervals from one rising edge to the next count as periods. The first rising edge after reset or after a timeout only starts timing, so a lone edge never produces a result with a non-zero count.
- R3: At every refresh boundary where at least one period has ended since the previous boundary, `result_valid` pulses for one cycle. With it, `period_count` gives the number of those periods and `tick_total` gives the exact sum of their lengths in reference cycles. An input period that is still running carries on timing across the boundary.
- R4: `period_count` never exceeds `MAX_PERIODS`. Once the cap is reached, rising edges are ignored until the next boundary. Timing resumes at the first rising edge after that boundary, so a result at the cap holds `MAX_PERIODS` full periods.
- R5: An input period longer than the refresh window is reported at the first boundary after it ends, with `period_count` = 1 and `tick_total` equal to its length.
- R6: Suppose `timeout_ticks` cycles pass with no rising edge. On the next cycle `no_signal` rises, `result_valid` pulses with `period_count` = 0 and `tick_total` = 0, and any partly built result is discarded. A result with count 0 occurs only in this case.
- R7: `no_signal` stays at 1 with no further results until the next rising edge. That edge clears the flag and only re-arms timing, as in R2.
- R8: A `refresh_ticks` value of N ≥ 1 places boundaries exactly N cycles apart. Between pulses of `result_valid`, the outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all ticks are counted in this clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_in | input | 1 | Asynchronous input being measured |
| refresh_ticks | input | CNT_W | Refresh window length in reference cycles |
| timeout_ticks | input | CNT_W | Cycles without a rising edge before the input is declared absent |
| tick_total | output | CNT_W+1 | Sum of reference ticks over the periods counted in the result |
| period_count | output | $clog2(MAX_PERIODS+1) | Number of whole periods in the result; 0 marks a timeout |
| result_valid | output | 1 | One-cycle strobe when a new result is presented |
| no_signal | output | 1 | High from a timeout until the next rising edge |

## Verification
The hardest case to reach from the ports is the cap. It needs a rising edge that arrives after a capped window has closed and that must start a fresh interval, not close a stale one. The stimulus uses a 10-cycle input against a 1000-cycle window. This fills the 32-period cap about a third of the way through every window and leaves a run of ignored edges before each boundary. The bench then requires each result to total exactly 320 ticks, which any period started at the boundary, or left stale across it, would break. A lone pulse followed by silence reaches the timeout with the block armed but no period completed. The bench confirms that the only result is the zero-count one.

// File: rtl/recip_period_meter.sv
module recip_period_meter #(
  parameter int CNT_W       = 32,
  parameter int MAX_PERIODS = 32,
  localparam int ACC_W      = CNT_W + 1,
  localparam int PCNT_W     = $clog2(MAX_PERIODS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  input  logic [CNT_W-1:0]  refresh_ticks,
  input  logic [CNT_W-1:0]  timeout_ticks,
  output logic [ACC_W-1:0]  tick_total,
  output logic [PCNT_W-1:0] period_count,
  output logic              result_valid,
  output logic              no_signal
);

  logic [2:0]        sync_q;
  logic [CNT_W-1:0]  win_q, idle_q;
  logic [ACC_W-1:0]  per_q, acc_q;
  logic [PCNT_W-1:0] np_q;
  logic              armed_q, capped_q, idle_run_q;

  wire rise = sync_q[1] & ~sync_q[2];

  wire [CNT_W:0] win_nx   = {1'b0, win_q} + 1'b1;
  wire           boundary = win_nx >= {1'b0, refresh_ticks};

  wire [CNT_W:0] idle_nx  = {1'b0, idle_q} + 1'b1;
  wire           tmo      = idle_run_q & ~rise & (idle_nx >= {1'b0, timeout_ticks});

  wire              complete = rise & armed_q & ~capped_q;
  wire [ACC_W-1:0]  acc_nx   = acc_q + (complete ? per_q : '0);
  wire [PCNT_W-1:0] np_nx    = np_q + PCNT_W'(complete);
  wire              hit_cap  = complete & (np_nx == PCNT_W'(MAX_PERIODS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q       <= '0;
      win_q        <= '0;
      idle_q       <= '0;
      idle_run_q   <= 1'b1;
      per_q        <= '0;
      acc_q        <= '0;
      np_q         <= '0;
      armed_q      <= 1'b0;
      capped_q     <= 1'b0;
      tick_total   <= '0;
      period_count <= '0;
      result_valid <= 1'b0;
      no_signal    <= 1'b0;
    end else begin
      sync_q       <= {sync_q[1:0], sig_in};
      win_q        <= boundary ? '0 : win_nx[CNT_W-1:0];
      result_valid <= 1'b0;

      if (rise) begin
        idle_q     <= '0;
        idle_run_q <= 1'b1;
        no_signal  <= 1'b0;
      end else if (tmo) begin
        idle_run_q <= 1'b0;
        no_signal  <= 1'b1;
      end else if (idle_run_q) begin
        idle_q <= idle_nx[CNT_W-1:0];
      end

      if (rise)         per_q <= ACC_W'(1);
      else if (armed_q) per_q <= per_q + 1'b1;

      if (tmo) begin
        result_valid <= 1'b1;
        tick_total   <= '0;
        period_count <= '0;
        acc_q        <= '0;
        np_q         <= '0;
        armed_q      <= 1'b0;
        capped_q     <= 1'b0;
      end else begin
        if (boundary) begin
          if (np_nx != '0) begin
            result_valid <= 1'b1;
            tick_total   <= acc_nx;
            period_count <= np_nx;
          end
          acc_q    <= '0;
          np_q     <= '0;
          capped_q <= 1'b0;
        end else begin
          acc_q <= acc_nx;
          np_q  <= np_nx;
          if (hit_cap) capped_q <= 1'b1;
        end
        if (rise && !armed_q && !capped_q) armed_q <= 1'b1;
        else if (hit_cap && !boundary)     armed_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/recip_period_meter_chk.sv
module recip_period_meter_chk #(
  parameter int MAX_PERIODS = 32,
  parameter int ACC_W       = 33,
  parameter int PCNT_W      = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ACC_W-1:0]  tick_total,
  input logic [PCNT_W-1:0] period_count,
  input logic              result_valid,
  input logic              no_signal
);

  p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> period_count <= PCNT_W'(MAX_PERIODS));

  p_timeout_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_signal) |-> (result_valid && period_count == '0 && tick_total == '0));

  p_zero_only_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && period_count == '0) |-> no_signal);

  p_flag_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (no_signal && $past(no_signal)) |-> !result_valid);

  p_rearm_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(no_signal) |-> !result_valid);

  p_total_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && period_count != '0) |-> tick_total >= ACC_W'(period_count));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> ($stable(period_count) && $stable(tick_total)));

endmodule

bind recip_period_meter recip_period_meter_chk #(
  .MAX_PERIODS(MAX_PERIODS), .ACC_W(ACC_W), .PCNT_W(PCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_total(tick_total),
  .period_count(period_count), .result_valid(result_valid), .no_signal(no_signal)
);

// File: tb/recip_period_meter_tb.sv
module recip_period_meter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;
  localparam int MAXP  = 32;
  localparam int ACC_W = CNT_W + 1;
  localparam int PCNT_W = $clog2(MAXP + 1);
  localparam int WATCHDOG = 150000;

  logic clk = 0, rst_n = 0, sig_in = 0;
  logic [CNT_W-1:0] refresh_ticks = 1000, timeout_ticks = 20000;
  logic [ACC_W-1:0] tick_total;
  logic [PCNT_W-1:0] period_count;
  logic result_valid, no_signal;

  recip_period_meter #(.CNT_W(CNT_W), .MAX_PERIODS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
    .refresh_ticks(refresh_ticks), .timeout_ticks(timeout_ticks),
    .tick_total(tick_total), .period_count(period_count),
    .result_valid(result_valid), .no_signal(no_signal));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int gen_half = 0, gcnt = 0;
  int res_n = 0, res_cnt = 0, res_flag = 0, res_gap = 0, last_cyc = 0;
  longint res_total = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (gen_half == 0) begin sig_in <= 0; gcnt <= 0; end
    else if (gcnt >= gen_half - 1) begin sig_in <= ~sig_in; gcnt <= 0; end
    else gcnt <= gcnt + 1;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (result_valid) begin
      res_n++;
      res_total = longint'(tick_total);
      res_cnt   = int'(period_count);
      res_flag  = int'(no_signal);
      res_gap   = cyc - last_cyc;
      last_cyc  = cyc;
    end
    if (cyc > WATCHDOG && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual cycles %0d expected < %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_res(input int maxcyc, input string req);
    int start = res_n;
    for (int i = 0; i < maxcyc && res_n == start; i++) @(negedge clk);
    check(res_n != start, req, res_n - start, 1);
    @(negedge clk);
  endtask

  task automatic do_reset(input int refr, input int tmo, input int half);
    gen_half = 0;
    rst_n = 0;
    refresh_ticks = CNT_W'(refr);
    timeout_ticks = CNT_W'(tmo);
    repeat (5) @(negedge clk);
    rst_n = 1;
    gen_half = half;
  endtask

  task automatic t_reset;
    gen_half = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    check(result_valid == 0 && no_signal == 0, "R1 flags in reset", {result_valid, no_signal}, 0);
    check(tick_total == 0 && period_count == 0, "R1 data in reset", tick_total, 0);
    rst_n = 1;
    @(negedge clk);
    check(result_valid == 0 && period_count == 0 && no_signal == 0, "R1 after release",
          period_count, 0);
  endtask

  task automatic t_steady;
    do_reset(1000, 20000, 50);
    repeat (2) wait_res(3000, "R3 steady startup");
    for (int k = 0; k < 3; k++) begin
      wait_res(3000, "R3 steady result");
      check(res_cnt == 10, "R3 steady count", res_cnt, 10);
      check(res_total == 1000, "R3 steady total", res_total, 1000);
      check(res_gap == 1000, "R8 boundary spacing", res_gap, 1000);
    end
  endtask

  task automatic t_uneven;
    do_reset(1000, 20000, 75);
    repeat (2) wait_res(3000, "R3 uneven startup");
    for (int k = 0; k < 4; k++) begin
      wait_res(3000, "R3 uneven result");
      check(res_cnt == 6 || res_cnt == 7, "R3 uneven count", res_cnt, 7);
      check(res_total == longint'(res_cnt) * 150, "R3 uneven total", res_total,
            longint'(res_cnt) * 150);
    end
  endtask

  task automatic t_cap;
    do_reset(1000, 20000, 5);
    repeat (2) wait_res(3000, "R4 cap startup");
    for (int k = 0; k < 3; k++) begin
      wait_res(3000, "R4 cap result");
      check(res_cnt == MAXP, "R4 capped count", res_cnt, MAXP);
      check(res_total == MAXP * 10, "R4 capped total", res_total, MAXP * 10);
    end
  endtask

  task automatic t_slow;
    do_reset(1000, 20000, 1500);
    wait_res(8000, "R5 slow startup");
    for (int k = 0; k < 2; k++) begin
      wait_res(8000, "R5 slow result");
      check(res_cnt == 1, "R5 long period count", res_cnt, 1);
      check(res_total == 3000, "R5 long period total", res_total, 3000);
      check(res_flag == 0, "R5 no timeout", res_flag, 0);
    end
  endtask

  task automatic t_timeout;
    int n0;
    do_reset(1000, 3000, 20);
    repeat (30) @(negedge clk);
    gen_half = 0;
    wait_res(8000, "R6 timeout result");
    check(res_cnt == 0, "R2 lone edge gives no period; R6 zero count", res_cnt, 0);
    check(res_total == 0, "R6 zero total", res_total, 0);
    check(res_flag == 1, "R6 flag with result", res_flag, 1);
    n0 = res_n;
    repeat (4000) @(negedge clk);
    check(no_signal == 1, "R7 flag held", no_signal, 1);
    check(res_n == n0, "R7 no further results", res_n - n0, 0);
    gen_half = 50;
    repeat (200) @(negedge clk);
    check(no_signal == 0, "R7 flag cleared by edge", no_signal, 0);
    repeat (2) wait_res(3000, "R7 restart startup");
    wait_res(3000, "R7 restart result");
    check(res_cnt == 10 && res_total == 1000, "R7 restart measurement", res_total, 1000);
  endtask

  initial begin
    t_reset;
    t_steady;
    t_uneven;
    t_cap;
    t_slow;
    t_timeout;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule